// File: doc/BRIEF.md
# Configurable LUT Logic Cell

A single programmable logic cell. Two 4-input lookup tables (F and G) each realise any Boolean function of their own four inputs. A third, 3-input lookup table (H) can combine the F and G results with external inputs. Two output multiplexers pick what reaches the combinational outputs. Two storage elements, each configurable as an edge-triggered flip-flop or as a level-sensitive latch, drive the registered outputs. With this arrangement the cell covers any function of five variables and some functions of up to nine.

All behaviour comes from a 52-bit configuration word. The word is shifted in serially, most significant bit first, while the cell is held in configuration mode. In user mode the cell takes thirteen logic inputs and drives four outputs. Configuration mode forces every output low and freezes both storage elements. A synchronous global reset clears the storage elements. The active-low asynchronous reset clears both the storage elements and the configuration.

Top module: `lut_cell`

## Requirements
- R1: F' = f_tt[f_i] and G' = g_tt[g_i], where f_i[0] and g_i[0] are index bit 0.
- R2: H' = h_tt[{h1_i, b, a}]. b is F' when the h_b_from_f bit is 1 and h2_i otherwise. a is G' when the h_a_from_g bit is 1 and h0_i otherwise.
- R3: In user mode, x_o is H' when x_from_h is 1 and F' otherwise. y_o is H' when y_from_h is 1 and G' otherwise.
- R4: Each storage element selects its data with a 2-bit code: 0 = F', 1 = G', 2 = H', 3 = din_i.
- R5: In flip-flop mode, a storage element loads its data on the rising clk_i edge when ce_i is 1 or its ce_use bit is 0. Otherwise it holds its value.
- R6: In latch mode, the registered output follows its data combinationally while the element is enabled (ce_i is 1 or ce_use is 0). Once disabled, it holds the value captured at the last enabled clock edge.
- R7: gsr_i high at a rising clk_i edge clears both storage elements to 0. This takes priority over loading.
- R8: Configuration shifts one bit per rising clk_i edge, MSB first, only while cfg_mode_i and cfg_shift_i are both 1.
  - Word layout from MSB down: f_tt[15:0], g_tt[15:0], h_tt[7:0], h_b_from_f, h_a_from_g, x_from_h, y_from_h, xq{src[1:0], latch, ce_use}, yq{src[1:0], latch, ce_use}.
  - cfg_shift_i has no effect when cfg_mode_i is 0.
- R9: While cfg_mode_i is 1, all four outputs are 0 and both storage elements keep their values.
- R10: rst_ni low clears the configuration and both storage elements asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for storage elements and configuration shift |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 1 | Configuration mode |
| cfg_shift_i | input | 1 | Shift strobe for one configuration bit |
| cfg_data_i | input | 1 | Serial configuration data |
| gsr_i | input | 1 | Synchronous clear of storage elements |
| f_i | input | 4 | F table inputs |
| g_i | input | 4 | G table inputs |
| h0_i | input | 1 | External H input (alternative to G') |
| h1_i | input | 1 | External H input, always used |
| h2_i | input | 1 | External H input (alternative to F') |
| din_i | input | 1 | Direct storage data input |
| ce_i | input | 1 | Clock enable |
| x_o | output | 1 | Combinational output X |
| y_o | output | 1 | Combinational output Y |
| xq_o | output | 1 | Registered output XQ |
| yq_o | output | 1 | Registered output YQ |

## Verification
The assertions assume that the configuration changes only in configuration mode. They also assume that gsr_i and ce_i are clean levels sampled at the rising edge.

The bench drives every input at the falling edge, so setup is always met. It loads each configuration completely before it leaves configuration mode. It also pulses cfg_shift_i outside configuration mode to confirm that such pulses are ignored.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int unsigned F_K    = 4;
  localparam int unsigned G_K    = 4;
  localparam int unsigned H_K    = 3;
  localparam int unsigned F_BITS = 1 << F_K;
  localparam int unsigned G_BITS = 1 << G_K;
  localparam int unsigned H_BITS = 1 << H_K;

  typedef enum logic [1:0] {
    SRC_F   = 2'd0,
    SRC_G   = 2'd1,
    SRC_H   = 2'd2,
    SRC_DIN = 2'd3
  } store_src_e;

  typedef struct packed {
    store_src_e src;
    logic       latch;
    logic       ce_use;
  } store_cfg_t;

  typedef struct packed {
    logic [F_BITS-1:0] f_tt;
    logic [G_BITS-1:0] g_tt;
    logic [H_BITS-1:0] h_tt;
    logic              h_b_from_f;
    logic              h_a_from_g;
    logic              x_from_h;
    logic              y_from_h;
    store_cfg_t        xq;
    store_cfg_t        yq;
  } cell_cfg_t;

  localparam int unsigned CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/lut_cell_lut.sv
module lut_cell_lut #(
  parameter int unsigned K = 4
) (
  input  logic [(1<<K)-1:0] tt_i,
  input  logic [K-1:0]      idx_i,
  output logic              o_o
);
  assign o_o = tt_i[idx_i];
endmodule

// File: rtl/lut_cell_cfg.sv
module lut_cell_cfg #(
  parameter int unsigned W = 52
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         shift_i,
  input  logic         data_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cfg_q <= '0;
    else if (mode_i && shift_i) cfg_q <= {cfg_q[W-2:0], data_i};
  end

  assign cfg_o = cfg_q;

  // R8: word frozen outside config mode
  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> $stable(cfg_q));
endmodule

// File: rtl/lut_cell_store.sv
module lut_cell_store
  import lut_cell_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gsr_i,
  input  logic       hold_i,
  input  logic       ce_i,
  input  store_cfg_t cfg_i,
  input  logic       f_i,
  input  logic       g_i,
  input  logic       h_i,
  input  logic       din_i,
  output logic       q_o
);
  logic d, en, q_r;

  always_comb begin
    unique case (cfg_i.src)
      SRC_F:   d = f_i;
      SRC_G:   d = g_i;
      SRC_H:   d = h_i;
      default: d = din_i;
    endcase
  end

  assign en = !hold_i && (ce_i || !cfg_i.ce_use);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_r <= 1'b0;
    else if (gsr_i) q_r <= 1'b0;
    else if (en)    q_r <= d;
  end

  // latch mode: transparent while gate open
  assign q_o = (cfg_i.latch && en && !gsr_i) ? d : q_r;

  a_r5_hold_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !gsr_i) |=> $stable(q_r));
  a_r7_gsr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gsr_i |=> (q_r == 1'b0));
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_mode_i,
  input  logic           cfg_shift_i,
  input  logic           cfg_data_i,
  input  logic           gsr_i,
  input  logic [F_K-1:0] f_i,
  input  logic [G_K-1:0] g_i,
  input  logic           h0_i,
  input  logic           h1_i,
  input  logic           h2_i,
  input  logic           din_i,
  input  logic           ce_i,
  output logic           x_o,
  output logic           y_o,
  output logic           xq_o,
  output logic           yq_o
);
  logic [CFG_W-1:0] cfg_vec;
  cell_cfg_t        cfg;
  logic             f_out, g_out, h_out, h_b, h_a;
  logic             xq_raw, yq_raw;

  lut_cell_cfg #(.W(CFG_W)) i_cfg (
    .clk_i, .rst_ni, .mode_i(cfg_mode_i), .shift_i(cfg_shift_i),
    .data_i(cfg_data_i), .cfg_o(cfg_vec)
  );
  assign cfg = cell_cfg_t'(cfg_vec);

  lut_cell_lut #(.K(F_K)) i_lut_f (.tt_i(cfg.f_tt), .idx_i(f_i), .o_o(f_out));
  lut_cell_lut #(.K(G_K)) i_lut_g (.tt_i(cfg.g_tt), .idx_i(g_i), .o_o(g_out));

  assign h_b = cfg.h_b_from_f ? f_out : h2_i;
  assign h_a = cfg.h_a_from_g ? g_out : h0_i;
  lut_cell_lut #(.K(H_K)) i_lut_h (.tt_i(cfg.h_tt), .idx_i({h1_i, h_b, h_a}), .o_o(h_out));

  lut_cell_store i_store_x (
    .clk_i, .rst_ni, .gsr_i, .hold_i(cfg_mode_i), .ce_i, .cfg_i(cfg.xq),
    .f_i(f_out), .g_i(g_out), .h_i(h_out), .din_i, .q_o(xq_raw)
  );
  lut_cell_store i_store_y (
    .clk_i, .rst_ni, .gsr_i, .hold_i(cfg_mode_i), .ce_i, .cfg_i(cfg.yq),
    .f_i(f_out), .g_i(g_out), .h_i(h_out), .din_i, .q_o(yq_raw)
  );

  assign x_o  = !cfg_mode_i && (cfg.x_from_h ? h_out : f_out);
  assign y_o  = !cfg_mode_i && (cfg.y_from_h ? h_out : g_out);
  assign xq_o = !cfg_mode_i && xq_raw;
  assign yq_o = !cfg_mode_i && yq_raw;

  a_r9_cfg_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mode_i |-> ({x_o, y_o, xq_o, yq_o} == 4'b0));
  a_r3_x_from_f: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_i && !cfg.x_from_h) |-> (x_o == f_out));
  a_r3_y_from_g: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_i && !cfg.y_from_h) |-> (y_o == g_out));
endmodule

// File: tb/test_lut_cell.sv
`timescale 1ns/1ps
module test_lut_cell;
  import lut_cell_pkg::*;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_mode = 1'b0, cfg_shift = 1'b0, cfg_data = 1'b0, gsr = 1'b0;
  logic [3:0] f = '0, g = '0;
  logic h0 = 1'b0, h1 = 1'b0, h2 = 1'b0, din = 1'b0, ce = 1'b0;
  logic x, y, xq, yq;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  lut_cell i_lut_cell (
    .clk_i(clk), .rst_ni, .cfg_mode_i(cfg_mode), .cfg_shift_i(cfg_shift),
    .cfg_data_i(cfg_data), .gsr_i(gsr), .f_i(f), .g_i(g), .h0_i(h0), .h1_i(h1),
    .h2_i(h2), .din_i(din), .ce_i(ce), .x_o(x), .y_o(y), .xq_o(xq), .yq_o(yq)
  );

  // {h1, shared F/G index}
  localparam logic [4:0] VEC [16] = '{5'h00, 5'h01, 5'h07, 5'h0A, 5'h0F, 5'h13, 5'h15, 5'h18,
                                      5'h1C, 5'h1F, 5'h04, 5'h12, 5'h09, 5'h1B, 5'h0E, 5'h11};
  localparam logic [15:0] TT_F5 = 16'hA5C3;
  localparam logic [15:0] TT_G5 = 16'h1E78;

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_cfg(input cell_cfg_t c);
    logic [CFG_W-1:0] v;
    v = c;
    @(negedge clk);
    cfg_mode = 1'b1;
    for (int i = CFG_W - 1; i >= 0; i--) begin
      cfg_data  = v[i];
      cfg_shift = 1'b1;
      @(negedge clk);
    end
    cfg_shift = 1'b0;
    #1 check("R9 outputs low in config mode", x | y | xq | yq, 1'b0);
    cfg_mode = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cell_cfg_t c;
    logic [15:0] lf;

    // reset state
    #7;
    check("R10 reset x", x, 1'b0);
    check("R10 reset xq", xq, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    // five-input function: x = h1 ? F(a) : G(a)
    c = '0;
    c.f_tt = TT_F5; c.g_tt = TT_G5; c.h_tt = 8'hCA;
    c.h_b_from_f = 1'b1; c.h_a_from_g = 1'b1; c.x_from_h = 1'b1;
    f = 4'hF; g = 4'hF; h1 = 1'b1;
    load_cfg(c);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      f = VEC[i][3:0]; g = VEC[i][3:0]; h1 = VEC[i][4];
      h0 = ~h0; h2 = ~h2;
      #1;
      check("R1 R2 R3 five-input x", x, VEC[i][4] ? TT_F5[VEC[i][3:0]] : TT_G5[VEC[i][3:0]]);
      check("R1 R3 y from G", y, TT_G5[VEC[i][3:0]]);
    end

    // nine-input parity on x
    c = '0;
    c.f_tt = 16'h6996; c.g_tt = 16'h6996; c.h_tt = 8'h96;
    c.h_b_from_f = 1'b1; c.h_a_from_g = 1'b1; c.x_from_h = 1'b1;
    load_cfg(c);
    lf = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      f = lf[3:0]; g = lf[7:4]; h1 = lf[8]; h0 = lf[9]; h2 = lf[10];
      #1;
      check("R2 nine-input parity", x, ^{f, g, h1});
      check("R3 y parity of g", y, ^g);
    end

    // H from external pins: majority, xq flop from H without enable
    c = '0;
    c.h_tt = 8'hE8; c.x_from_h = 1'b1; c.y_from_h = 1'b1;
    c.xq.src = SRC_H;
    c.yq.src = SRC_G; c.g_tt = 16'hFFFF;
    load_cfg(c);
    ce = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {h1, h2, h0} = 3'(i);
      #1;
      check("R2 R3 external majority x", x, (h1 & h2) | (h1 & h0) | (h2 & h0));
      check("R3 y from H", y, (h1 & h2) | (h1 & h0) | (h2 & h0));
      @(negedge clk);
      check("R4 R5 xq samples H ignoring ce", xq, (h1 & h2) | (h1 & h0) | (h2 & h0));
      check("R4 yq samples G", yq, 1'b1);
    end

    // flop on DIN with enable, latch on F with enable
    c = '0;
    c.f_tt = 16'hFF00;
    c.xq.src = SRC_DIN; c.xq.ce_use = 1'b1;
    c.yq.src = SRC_F; c.yq.latch = 1'b1; c.yq.ce_use = 1'b1;
    gsr = 1'b1;
    load_cfg(c);
    @(negedge clk);
    gsr = 1'b0;
    din = 1'b1; ce = 1'b0; f = 4'h0;
    @(negedge clk);
    check("R5 flop holds with ce low", xq, 1'b0);
    ce = 1'b1; f = 4'h8;
    #1 check("R6 latch transparent", yq, 1'b1);
    @(negedge clk);
    check("R5 flop loads with ce high", xq, 1'b1);
    ce = 1'b0; f = 4'h0; din = 1'b0;
    #1 check("R6 latch holds when closed", yq, 1'b1);
    @(negedge clk);
    check("R5 flop holds after ce drop", xq, 1'b1);
    gsr = 1'b1;
    @(negedge clk);
    gsr = 1'b0;
    #1;
    check("R7 gsr clears xq", xq, 1'b0);
    check("R7 gsr clears yq", yq, 1'b0);

    // config mode freezes storage
    ce = 1'b1; din = 1'b1;
    @(negedge clk);
    cfg_mode = 1'b1; din = 1'b0;
    #1 check("R9 xq low in config mode", xq, 1'b0);
    @(negedge clk);
    @(negedge clk);
    cfg_mode = 1'b0; ce = 1'b0;
    #1 check("R9 storage kept through config mode", xq, 1'b1);

    // shift strobe ignored outside config mode
    f = 4'h8;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cfg_shift = 1'b1; cfg_data = i[0];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
    #1 check("R8 shift ignored in user mode", x, 1'b1);
    f = 4'h7;
    #1 check("R8 F table unchanged", x, 1'b0);

    // MSB-first order: one bit shifted changes f_tt[0] position only after full word
    c = '0;
    c.f_tt = 16'h0001;
    load_cfg(c);
    f = 4'h0;
    #1 check("R8 MSB-first lands f_tt bit0", x, 1'b1);
    f = 4'h1;
    #1 check("R8 other entries zero", x, 1'b0);

    // asynchronous reset mid-run
    f = 4'h0; ce = 1'b1; din = 1'b1;
    @(negedge clk);
    #1;
    rst_ni = 1'b0;
    #0.5 check("R10 async reset clears config", x, 1'b0);
    check("R10 async reset clears xq", xq, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule